// File: doc/BRIEF.md
# Guarded Conditional Move Unit

This execute-stage block performs one guarded move per clock. Each operation carries a 64-bit test value, a 64-bit register source, a 64-bit immediate, a flag choosing between the register source and the immediate, a 3-bit condition code and a 5-bit destination index. The block evaluates the chosen condition on the test value alone. When the condition holds, it issues a write of the chosen source value to the destination. When the condition fails, the operation retires as a no-op and no write is issued.

All outputs are registered and appear one cycle after the operation is presented. Writeback logic downstream uses the write strobe, the data and the destination index exactly as they come out of this block.

Top module: `gcmov_unit`

## Requirements
- R1: After a synchronous active-high reset, `wr_en_o` and `taken_o` are 0.
- R2: Outputs are registered. An operation presented with `op_valid_i`=1 at clock edge N sets the outputs at edge N+1.
- R3: When `op_valid_i` is 0, `wr_en_o` and `taken_o` are 0 on the following cycle, whatever the other inputs are.
- R4: Codes 000 (zero) and 001 (nonzero) test whether `test_i` equals zero.
- R5: Codes 010 (negative), 011 (negative or zero), 100 (positive) and 101 (positive or zero) compare `test_i` as a two's-complement signed value, with bit 63 as the sign bit.
- R6: Codes 110 and 111 look only at bit 0 of `test_i`. Code 110 passes when bit 0 is clear, and code 111 passes when bit 0 is set.
- R7: When `use_imm_i`=1, the write data is `imm_i`. When `use_imm_i`=0, the write data is `src_i`.
- R8: When the guard fails, `wr_en_o`=0 and `taken_o`=0. When the guard passes on a valid operation, both are 1.
- R9: The guard depends only on `test_i` and the condition code. The value of `src_i` never changes it.
- R10: `rd_o` carries the `rd_i` of the operation that produced the current outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | Operation strobe |
| cond_i | input | 3 | Condition code |
| use_imm_i | input | 1 | 1 selects the immediate as the source |
| test_i | input | 64 | Test operand |
| src_i | input | 64 | Register source operand |
| imm_i | input | 64 | Immediate source operand |
| rd_i | input | 5 | Destination register index |
| wr_en_o | output | 1 | Destination write enable |
| wr_data_o | output | 64 | Data to write |
| rd_o | output | 5 | Destination index, forwarded |
| taken_o | output | 1 | Guard passed on a valid operation |

## Verification
The bench targets the boundary values of the signed tests: zero, one, minus one, the most negative value and the most positive value. A design that compared unsigned would treat negative values as large positives. A design that mixed up strict and non-strict comparisons would flip its answer when the test value is zero.

The low-bit tests use values whose sign and zero status disagree with bit 0. A design that tested the wrong bit, or reused a sign test, would get these wrong.

Other operations are chosen to expose specific faults:
- Operations whose `src_i` would change a signed result catch a guard wired to the wrong operand.
- Back-to-back operations with `op_valid_i` dropped in between catch a write strobe that does not clear.
- Operations on both sides of `use_imm_i` catch an inverted source select.

// File: rtl/gcmov_pkg.sv
package gcmov_pkg;
    localparam int XLEN = 64;
    localparam int RIDX = 5;

    typedef enum logic [2:0] {
        C_ZERO  = 3'b000,
        C_NZERO = 3'b001,
        C_NEG   = 3'b010,
        C_NPOS  = 3'b011,
        C_POS   = 3'b100,
        C_NNEG  = 3'b101,
        C_BCLR  = 3'b110,
        C_BSET  = 3'b111
    } cond_e;

    typedef struct packed {
        logic            is_zero;
        logic            is_neg;
        logic            bit0;
    } flags_t;

    typedef struct packed {
        logic            wr_en;
        logic            taken;
        logic [XLEN-1:0] data;
        logic [RIDX-1:0] rd;
    } result_t;

    function automatic logic guard_eval(cond_e c, flags_t f);
        logic g;
        unique case (c)
            C_ZERO:  g = f.is_zero;
            C_NZERO: g = !f.is_zero;
            C_NEG:   g = f.is_neg;
            C_NPOS:  g = f.is_neg | f.is_zero;
            C_POS:   g = !f.is_neg & !f.is_zero;
            C_NNEG:  g = !f.is_neg;
            C_BCLR:  g = !f.bit0;
            C_BSET:  g = f.bit0;
            default: g = 1'b0;
        endcase
        return g;
    endfunction
endpackage

// File: rtl/gcmov_flags.sv
module gcmov_flags
    import gcmov_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] val_i,
    output flags_t       flags_o
);
    always_comb begin
        flags_o.is_zero = (val_i == '0);
        flags_o.is_neg  = val_i[W-1];
        flags_o.bit0    = val_i[0];
    end

    always_comb begin
        a_r5_sign_flag: assert (flags_o.is_neg == ($signed(val_i) < 0));
    end
endmodule

// File: rtl/gcmov_guard.sv
module gcmov_guard
    import gcmov_pkg::*;
(
    input  logic [2:0] cond_i,
    input  flags_t     flags_i,
    output logic       pass_o
);
    always_comb begin
        pass_o = guard_eval(cond_e'(cond_i), flags_i);
    end

    always_comb begin
        if (cond_i[2:1] == 2'b11)
            a_r6_low_bit: assert (pass_o == (flags_i.bit0 == cond_i[0]));
    end
endmodule

// File: rtl/gcmov_unit.sv
module gcmov_unit
    import gcmov_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid_i,
    input  logic [2:0]      cond_i,
    input  logic            use_imm_i,
    input  logic [63:0]     test_i,
    input  logic [63:0]     src_i,
    input  logic [63:0]     imm_i,
    input  logic [4:0]      rd_i,
    output logic            wr_en_o,
    output logic [63:0]     wr_data_o,
    output logic [4:0]      rd_o,
    output logic            taken_o
);
    flags_t  flags;
    logic    pass;
    result_t res_q, res_d;

    gcmov_flags #(.W(XLEN)) u_flags (.val_i(test_i), .flags_o(flags));
    gcmov_guard u_guard (.cond_i(cond_i), .flags_i(flags), .pass_o(pass));

    always_comb begin
        res_d.taken = op_valid_i & pass;
        res_d.wr_en = op_valid_i & pass;
        res_d.data  = use_imm_i ? imm_i : src_i;
        res_d.rd    = rd_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign wr_en_o   = res_q.wr_en;
    assign taken_o   = res_q.taken;
    assign wr_data_o = res_q.data;
    assign rd_o      = res_q.rd;

    a_r3_idle_no_write: assert property (@(posedge clk) disable iff (rst)
        !op_valid_i |=> !wr_en_o);
    a_r10_rd_forward: assert property (@(posedge clk) disable iff (rst)
        op_valid_i |=> rd_o == $past(rd_i));
    a_r7_src_select: assert property (@(posedge clk) disable iff (rst)
        (op_valid_i && use_imm_i) |=> wr_data_o == $past(imm_i));
    a_r8_taken_tracks_wr: assert property (@(posedge clk) disable iff (rst)
        wr_en_o == taken_o);
    a_r4_zero_test: assert property (@(posedge clk) disable iff (rst)
        (op_valid_i && cond_i == 3'b000 && test_i != 64'd0) |=> !wr_en_o);
endmodule

// File: tb/gcmov_unit_tb.sv
module gcmov_unit_tb;
    logic clk = 0, rst = 1;
    logic op_valid_i = 0, use_imm_i = 0;
    logic [2:0] cond_i = 0;
    logic [63:0] test_i = 0, src_i = 0, imm_i = 0;
    logic [4:0] rd_i = 0;
    logic wr_en_o, taken_o;
    logic [63:0] wr_data_o;
    logic [4:0] rd_o;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    gcmov_unit u_dut (.*);

    localparam logic [63:0] MINV = 64'h8000_0000_0000_0000;
    localparam logic [63:0] MAXV = 64'h7fff_ffff_ffff_ffff;
    localparam logic [63:0] NEG1 = '1;

    function automatic logic model(logic [2:0] c, logic [63:0] t);
        logic signed [63:0] s;
        s = $signed(t);
        case (c)
            3'd0: return s == 0;
            3'd1: return s != 0;
            3'd2: return s < 0;
            3'd3: return s <= 0;
            3'd4: return s > 0;
            3'd5: return s >= 0;
            3'd6: return !t[0];
            default: return t[0];
        endcase
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one operation, then sample after the registering edge.
    task automatic run_op(string req, logic v, logic [2:0] c, logic imm_sel,
                          logic [63:0] t, logic [63:0] s, logic [63:0] im, logic [4:0] rd);
        logic g;
        @(negedge clk);
        op_valid_i = v; cond_i = c; use_imm_i = imm_sel;
        test_i = t; src_i = s; imm_i = im; rd_i = rd;
        @(negedge clk);
        g = v & model(c, t);
        chk(req, {63'd0, wr_en_o}, {63'd0, g});
        chk(req, {63'd0, taken_o}, {63'd0, g});
        if (v) begin
            chk("R7", wr_data_o, imm_sel ? im : s);
            chk("R10", {59'd0, rd_o}, {59'd0, rd});
        end
        op_valid_i = 0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1", {63'd0, wr_en_o}, 64'd0);
        chk("R1", {63'd0, taken_o}, 64'd0);
    endtask

    task automatic t_zero;
        run_op("R4", 1, 3'd0, 0, 64'd0, 64'h11, 64'h22, 5'd3);
        run_op("R4", 1, 3'd0, 0, 64'd1, 64'h11, 64'h22, 5'd4);
        run_op("R4", 1, 3'd1, 1, 64'd0, 64'h11, 64'h22, 5'd5);
        run_op("R4", 1, 3'd1, 1, MINV, 64'h11, 64'h22, 5'd6);
    endtask

    task automatic t_signed;
        logic [63:0] vals [5] = '{64'd0, 64'd1, NEG1, MINV, MAXV};
        for (int c = 2; c <= 5; c++)
            foreach (vals[i])
                run_op("R5", 1, 3'(c), i[0], vals[i], 64'hA5A5 + 64'(i), 64'hC3 + 64'(c), 5'(c + i));
    endtask

    task automatic t_lowbit;
        run_op("R6", 1, 3'd6, 0, 64'd2, 64'h1, 64'h2, 5'd7);
        run_op("R6", 1, 3'd6, 0, NEG1, 64'h1, 64'h2, 5'd8);
        run_op("R6", 1, 3'd7, 1, 64'd1, 64'h1, 64'h2, 5'd9);
        run_op("R6", 1, 3'd7, 1, MINV, 64'h1, 64'h2, 5'd10);
    endtask

    task automatic t_invalid;
        run_op("R3", 0, 3'd5, 0, 64'd5, 64'h1, 64'h2, 5'd1);
        run_op("R2", 1, 3'd5, 0, 64'd5, 64'hBEEF, 64'h2, 5'd31);
        run_op("R3", 0, 3'd1, 1, 64'd5, 64'h1, 64'h2, 5'd1);
    endtask

    task automatic t_src_indep;
        run_op("R9", 1, 3'd2, 0, 64'd4, NEG1, 64'h0, 5'd12);
        run_op("R9", 1, 3'd0, 0, 64'd4, 64'd0, 64'h0, 5'd13);
        run_op("R8", 1, 3'd4, 0, 64'd0, 64'd9, 64'h3, 5'd14);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_zero();
        t_signed();
        t_lowbit();
        t_invalid();
        t_src_indep();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule